// File: doc/BRIEF.md
# Processor-to-Memory Crossbar Switch

This block is a synchronous N-by-N crossbar. It links N requester ports, such as processors, to N target ports, such as memory modules. Each requester presents a request flag, a binary target index and a W-bit word. A per-row decoder turns the index into one-hot crosspoint enables. Each crosspoint gates the requester's word with its enable bit. Every target column then ORs the gated words of all rows into one word.

Each column has a fixed-priority arbiter, so at most one row drives a column at a time. A requester that keeps its request high with the same target keeps its column until it lets go. A requester whose column is taken, or whose column went to a higher-priority row, is reported as blocked for that cycle and must retry.

All results are registered. A request sampled at one clock edge shows up on the grant, blocked, target-valid and target-data outputs right after that edge.

Top module: `xbar_switch`

## Requirements
- R1: While reset (rst_n low) is held, every grant, blocked, target-valid and target-data output is zero.
- R2: A requester that asks for a free target, selected by tgt_addr equal to the target's binary index, has grant high and blocked low after the next rising edge. In the same cycle that target shows valid high and carries the requester's word.
- R3: A target that no granted requester addresses shows valid low and all-zero data.
- R4: A requester with req low asserts no crosspoint enable. It shows neither grant nor blocked, and its word appears on no target.
- R5: At most one crosspoint per column is enabled, so a target's data always equals exactly one requester's word.
- R6: When no current holder keeps a column and several requesters ask for it in the same cycle, the lowest-numbered requester is granted and the others are blocked.
- R7: A holder that keeps req high with an unchanged target keeps its column on the next cycle, even when a lower-numbered requester asks for it. The lower-numbered requester is blocked.
- R8: When a holder drops req or changes its target, the column it held can be granted to another requester in that same sampling cycle.
- R9: blocked is high exactly when the requester asked at the last edge and was not granted. grant and blocked are never high together.
- R10: Requesters that address pairwise distinct targets are all granted in the same cycle. Each target carries its own requester's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Request flag per requester |
| tgt_addr_i | input | N*AW | Binary target index per requester, requester i in bits [i*AW +: AW] |
| wdata_i | input | N*W | Word per requester, requester i in bits [i*W +: W] |
| grant_o | output | N | Requester was connected at the last edge |
| blocked_o | output | N | Requester asked but its column was not granted |
| tvalid_o | output | N | Target column is driven by a granted requester |
| tdata_o | output | N*W | Word delivered to each target, target j in bits [j*W +: W] |

## Verification
Every result comes from exactly one register stage. Inputs applied between edges are therefore due on all outputs just after the next rising edge. Nothing is due combinationally, and nothing takes two cycles. The bench changes inputs shortly after a rising edge and samples one nanosecond after the following edge, so each check reads the one cycle that answers the stimulus. Scenarios that depend on column ownership (R7, R8) chain their cycles on purpose. They check every cycle in turn, so the held or released state is observed before the next stimulus changes it.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned MAX_PORTS = 32;

  // Index of the lowest set bit; zero when no bit is set.
  function automatic int unsigned lowest_index(input logic [MAX_PORTS-1:0] v);
    int unsigned idx;
    idx = 0;
    for (int k = MAX_PORTS - 1; k >= 0; k--) begin
      if (v[k]) idx = k;
    end
    return idx;
  endfunction

  // One-hot vector with bit idx set; all zero when idx is out of range.
  function automatic logic [MAX_PORTS-1:0] onehot(input int unsigned idx);
    logic [MAX_PORTS-1:0] r;
    r = '0;
    if (idx < MAX_PORTS) r[idx] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/xbar_decoder.sv
module xbar_decoder #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  row_sel
);
  import xbar_pkg::*;
  logic [MAX_PORTS-1:0] full;

  always_comb begin
    full    = onehot(int'(addr));
    row_sel = req ? full[N-1:0] : '0;
  end
endmodule

// File: rtl/xbar_col_arb.sv
module xbar_col_arb #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] want,
  output logic [N-1:0] col_en
);
  import xbar_pkg::*;
  logic          own_v_q;
  logic [AW-1:0] own_q;
  logic          keep;
  int unsigned   winner;
  logic [MAX_PORTS-1:0] want_ext;
  logic [MAX_PORTS-1:0] win_full;

  always_comb begin
    want_ext = '0;
    want_ext[N-1:0] = want;
    keep     = own_v_q && want[own_q];
    winner   = keep ? int'(own_q) : lowest_index(want_ext);
    win_full = onehot(winner);
    col_en   = (|want) ? win_full[N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v_q <= 1'b0;
      own_q   <= '0;
    end else begin
      own_v_q <= |want;
      own_q   <= AW'(winner);
    end
  end
endmodule

// File: rtl/xbar_col_path.sv
module xbar_col_path #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0]   en,
  input  logic [N*W-1:0] rows,
  output logic [W-1:0]   col_word
);
  logic [N*W-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_xp
    assign gated[i*W +: W] = rows[i*W +: W] & {W{en[i]}};
  end

  always_comb begin
    col_word = '0;
    for (int i = 0; i < N; i++) col_word = col_word | gated[i*W +: W];
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_i,
  input  logic [N*AW-1:0] tgt_addr_i,
  input  logic [N*W-1:0] wdata_i,
  output logic [N-1:0]   grant_o,
  output logic [N-1:0]   blocked_o,
  output logic [N-1:0]   tvalid_o,
  output logic [N*W-1:0] tdata_o
);
  // Row-major request matrix and crosspoint enables: bit i*N+j is row i, column j.
  logic [N*N-1:0] want_rc;
  logic [N*N-1:0] xp_en;
  logic [N-1:0]   grant_d;
  logic [N-1:0]   colv_d;
  logic [N*W-1:0] col_d;

  for (genvar i = 0; i < N; i++) begin : g_row
    xbar_decoder #(.N(N), .AW(AW)) u_dec (
      .req     (req_i[i]),
      .addr    (tgt_addr_i[i*AW +: AW]),
      .row_sel (want_rc[i*N +: N])
    );
  end

  for (genvar j = 0; j < N; j++) begin : g_col
    logic [N-1:0] want_c;
    logic [N-1:0] en_c;
    for (genvar i = 0; i < N; i++) begin : g_tap
      assign want_c[i]       = want_rc[i*N + j];
      assign xp_en[i*N + j]  = en_c[i];
    end
    xbar_col_arb #(.N(N), .AW(AW)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .want   (want_c),
      .col_en (en_c)
    );
    xbar_col_path #(.N(N), .W(W)) u_path (
      .en       (en_c),
      .rows     (wdata_i),
      .col_word (col_d[j*W +: W])
    );
    assign colv_d[j] = |en_c;
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign grant_d[i] = |xp_en[i*N +: N];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_o   <= '0;
      blocked_o <= '0;
      tvalid_o  <= '0;
      tdata_o   <= '0;
    end else begin
      grant_o   <= grant_d;
      blocked_o <= req_i & ~grant_d;
      tvalid_o  <= colv_d;
      tdata_o   <= col_d;
    end
  end
endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_i,
  input logic [N*AW-1:0] tgt_addr_i,
  input logic [N*N-1:0]  xp_en,
  input logic [N-1:0]    grant_o,
  input logic [N-1:0]    blocked_o,
  input logic [N-1:0]    tvalid_o
);
  for (genvar j = 0; j < N; j++) begin : g_cj
    logic [N-1:0] col;
    for (genvar i = 0; i < N; i++) begin : g_b
      assign col[i] = xp_en[i*N + j];
    end
    AST_COL_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col)); // R5
  end

  for (genvar i = 0; i < N; i++) begin : g_ri
    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i[i] |-> (xp_en[i*N +: N] == '0)); // R4
    AST_GRANT_BLOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_o[i] && blocked_o[i])); // R9
    AST_BLOCK_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[i] |=> (grant_o[i] || blocked_o[i])); // R9
    AST_GRANT_DRIVES_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[i] && xp_en[i*N +: N] != '0) |=> tvalid_o[$past(tgt_addr_i[i*AW +: AW])]); // R2
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[i] && req_i[i] && $stable(tgt_addr_i[i*AW +: AW])) |=> grant_o[i]); // R7
  end
endmodule

bind xbar_switch xbar_switch_chk #(.N(N), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .tgt_addr_i (tgt_addr_i),
  .xp_en      (xp_en),
  .grant_o    (grant_o),
  .blocked_o  (blocked_o),
  .tvalid_o   (tvalid_o)
);

// File: tb/xbar_switch_tb.sv
module xbar_switch_tb_top;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req_i = '0;
  logic [N*AW-1:0] tgt_addr_i = '0;
  logic [N*W-1:0] wdata_i = '0;
  logic [N-1:0]   grant_o, blocked_o, tvalid_o;
  logic [N*W-1:0] tdata_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk; // 250 MHz

  xbar_switch #(.N(N), .W(W), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .tgt_addr_i(tgt_addr_i),
    .wdata_i(wdata_i), .grant_o(grant_o), .blocked_o(blocked_o),
    .tvalid_o(tvalid_o), .tdata_o(tdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int i, input logic r, input int t, input logic [W-1:0] d);
    req_i[i] = r;
    tgt_addr_i[i*AW +: AW] = AW'(t);
    wdata_i[i*W +: W] = d;
  endtask

  task automatic idle_all();
    req_i = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    drive(0, 1'b1, 1, 8'h11);
    tick();
    chk("R1 grant", 32'(grant_o), 0);
    chk("R1 blocked", 32'(blocked_o), 0);
    chk("R1 tvalid", 32'(tvalid_o), 0);
    chk("R1 tdata", tdata_o, 0);
    idle_all();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_single();
    drive(0, 1'b1, 2, 8'hA5);
    tick();
    chk("R2 grant", 32'(grant_o), 32'h1);
    chk("R2 blocked", 32'(blocked_o), 0);
    chk("R2 tvalid", 32'(tvalid_o), 32'h4);
    chk("R2 data", 32'(tdata_o[2*W +: W]), 32'hA5);
    chk("R3 other data", 32'({tdata_o[3*W +: W], tdata_o[0 +: 2*W]}), 0);
    idle_all();
    tick();
    chk("R4 idle grant", 32'(grant_o), 0);
    chk("R4 idle valid", 32'(tvalid_o), 0);
  endtask

  task automatic t_perm();
    drive(0, 1'b1, 3, 8'h10);
    drive(1, 1'b1, 2, 8'h21);
    drive(2, 1'b1, 1, 8'h32);
    drive(3, 1'b1, 0, 8'h43);
    tick();
    chk("R10 grant", 32'(grant_o), 32'hF);
    chk("R10 tvalid", 32'(tvalid_o), 32'hF);
    chk("R10 data", tdata_o, 32'h10213243);
    idle_all();
    tick();
  endtask

  task automatic t_contend_hold_release();
    drive(1, 1'b1, 1, 8'hB1);
    drive(2, 1'b1, 1, 8'hC2);
    drive(3, 1'b1, 1, 8'hD3);
    tick();
    chk("R6 grant", 32'(grant_o), 32'h2);
    chk("R6 blocked", 32'(blocked_o), 32'hC);
    chk("R5 data one driver", 32'(tdata_o[W +: W]), 32'hB1);
    chk("R3 unused valid", 32'(tvalid_o), 32'h2);
    // R7: lower-numbered requester joins; holder 1 keeps the column
    drive(0, 1'b1, 1, 8'h0E);
    tick();
    chk("R7 grant", 32'(grant_o), 32'h2);
    chk("R7 blocked", 32'(blocked_o), 32'hD);
    chk("R7 data", 32'(tdata_o[W +: W]), 32'hB1);
    // R8: holder drops; idle requester 1 must leave no trace (R4)
    drive(1, 1'b0, 1, 8'h77);
    drive(3, 1'b0, 1, 8'hD3);
    tick();
    chk("R8 grant", 32'(grant_o), 32'h1);
    chk("R8 blocked", 32'(blocked_o), 32'h4);
    chk("R8 data", 32'(tdata_o[W +: W]), 32'h0E);
    chk("R4 idle flags", 32'({grant_o[1], blocked_o[1]}), 0);
    // R8: holder 0 retargets to 3; column 1 goes to requester 2 at once
    drive(0, 1'b1, 3, 8'h0F);
    tick();
    chk("R8 retarget grant", 32'(grant_o), 32'h5);
    chk("R8 retarget valid", 32'(tvalid_o), 32'hA);
    chk("R8 retarget data", tdata_o, 32'h0F00C200);
    chk("R9 blocked cleared", 32'(blocked_o), 0);
    idle_all();
    tick();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_perm();
        t_contend_hold_release();
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule